// File: doc/BRIEF.md
# Three-Level Prioritised Interrupt Controller

This block arbitrates among a parameterised number of interrupt request lines and hands a single winner to the processor. Each line carries a private enable bit and a two-bit level code that places it in one of three priority classes or switches it off. A global enable gates every line at once. Each cycle the controller picks the highest-level eligible request, breaks ties inside a level by vector number, and presents that vector, its level and its handler address on registered outputs.

The processor takes the interrupt by pulsing an acknowledge. The controller then records that level as executing in a three-bit status vector, and from then on accepts only requests of a strictly higher level, which gives nesting. A return strobe retires the highest executing level. The low class can be switched from fixed to rotating priority, in which case the vector acknowledged last at low level drops to the back of the low queue. A base-select input moves the handler address between a table at address 0 and a table at a boot-section base.

Top module: `irq_level_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `irq_o` and `active_o` are 0 after that edge, and the rotation pointer returns to vector 0 (the last-acknowledged low vector counts as 0).
- R2: Level codes are 2'b00 off, 2'b01 low, 2'b10 medium, 2'b11 high. An eligible high request beats any medium one, and medium beats low; a line coded off never raises `irq_o`.
- R3: Within medium and high, and within low in fixed mode, the eligible request with the smallest vector number is presented.
- R4: A line is eligible only when its `req_i`, its `en_i` bit and `glb_en_i` are all 1.
- R5: A request is presented only if its level is strictly above the highest level set in `active_o`; equal or lower levels wait.
- R6: A cycle with `ack_i` and `irq_o` both high sets `active_o` bit `lvl_o-1` (bit 0 low, bit 1 medium, bit 2 high); after any cycle with `ack_i` or `reti_i` high, `irq_o` is 0 for one cycle.
- R7: A cycle with `reti_i` high clears the highest set bit of `active_o` and leaves the others.
- R8: With `rr_mode_i` at 1, the low-level search starts one above the last acknowledged low vector and wraps, so that vector is served last; medium and high stay fixed.
- R9: `vaddr_o` equals `vec_o * VEC_BYTES`, plus `BOOT_BASE` when `vbase_sel_i` was 1 in the arbitration cycle.
- R10: All outputs are registered: a change on the inputs appears on `irq_o`, `vec_o`, `lvl_o` and `vaddr_o` after the next clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_SRC | Request per line |
| en_i | input | N_SRC | Enable per line |
| lvl_cfg_i | input | 2*N_SRC | Level code per line, line k at bits 2k+1:2k |
| glb_en_i | input | 1 | Global interrupt enable |
| rr_mode_i | input | 1 | 1 selects rotating priority for the low level |
| vbase_sel_i | input | 1 | 1 places the handler table at BOOT_BASE |
| ack_i | input | 1 | Processor takes the presented interrupt |
| reti_i | input | 1 | Return from the current handler |
| irq_o | output | 1 | An interrupt is presented |
| vec_o | output | $clog2(N_SRC) | Presented vector number |
| lvl_o | output | 2 | Level of the presented vector |
| vaddr_o | output | VADDR_W | Handler address of the presented vector |
| active_o | output | 3 | Executing levels: bit 0 low, bit 1 medium, bit 2 high |

## Verification
Requests are applied in mixed patterns: several lines on one level (separating smallest-index selection from any other order), lines spread over all three levels (separating class priority from index order), and the same patterns with individual and global enables dropped (showing gating per line versus globally). Acknowledge and return sequences build and unwind nested levels, which tells strict-above acceptance apart from equal-level acceptance and shows which flag a return clears. Repeated take-and-return rounds on a fixed set of low requests tell the rotating order from the fixed one, and the base-select input is toggled to separate the two address tables.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam logic [1:0] LVL_OFF  = 2'd0;
  localparam logic [1:0] LVL_LOW  = 2'd1;
  localparam logic [1:0] LVL_MED  = 2'd2;
  localparam logic [1:0] LVL_HIGH = 2'd3;

  // Highest executing level encoded as a level code (0 when idle)
  function automatic logic [1:0] top_level(input logic [2:0] act);
    if (act[2])      return LVL_HIGH;
    else if (act[1]) return LVL_MED;
    else if (act[0]) return LVL_LOW;
    else             return LVL_OFF;
  endfunction
endpackage

// File: rtl/irq_level_mask.sv
module irq_level_mask import irq_lvl_pkg::*; #(
  parameter int N_SRC = 8
) (
  input  logic [N_SRC-1:0]   req_i,
  input  logic [N_SRC-1:0]   en_i,
  input  logic [2*N_SRC-1:0] lvl_cfg_i,
  input  logic               glb_en_i,
  output logic [N_SRC-1:0]   low_o,
  output logic [N_SRC-1:0]   med_o,
  output logic [N_SRC-1:0]   high_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_line
    logic       live;
    logic [1:0] code;
    assign live      = req_i[g] & en_i[g] & glb_en_i;
    assign code      = lvl_cfg_i[2*g +: 2];
    assign low_o[g]  = live & (code == LVL_LOW);
    assign med_o[g]  = live & (code == LVL_MED);
    assign high_o[g] = live & (code == LVL_HIGH);
  end
endmodule

// File: rtl/irq_fixed_pick.sv
module irq_fixed_pick #(
  parameter int N_SRC = 8,
  localparam int VEC_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             any_o,
  output logic [VEC_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = VEC_W'(i);
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
  parameter int N_SRC = 8,
  localparam int VEC_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic [VEC_W-1:0] last_i,
  output logic             any_o,
  output logic [VEC_W-1:0] idx_o
);
  logic [N_SRC-1:0] above;
  logic             up_any, all_any;
  logic [VEC_W-1:0] up_idx, all_idx;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) above[i] = req_i[i] & (VEC_W'(i) > last_i);
  end

  irq_fixed_pick #(.N_SRC(N_SRC)) u_upper (.req_i(above), .any_o(up_any),  .idx_o(up_idx));
  irq_fixed_pick #(.N_SRC(N_SRC)) u_wrap  (.req_i(req_i), .any_o(all_any), .idx_o(all_idx));

  assign any_o = all_any;
  assign idx_o = up_any ? up_idx : all_idx;
endmodule

// File: rtl/irq_status_track.sv
module irq_status_track import irq_lvl_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_i,
  input  logic [1:0] set_lvl_i,
  input  logic       clr_i,
  output logic [2:0] act_o,
  output logic [1:0] top_o
);
  logic [2:0] clr_mask, set_mask;

  assign top_o = top_level(act_o);

  always_comb begin
    clr_mask = '0;
    set_mask = '0;
    if (clr_i && top_o != LVL_OFF) clr_mask[top_o - 2'd1] = 1'b1;
    if (set_i && set_lvl_i != LVL_OFF) set_mask[set_lvl_i - 2'd1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) act_o <= '0;
    else     act_o <= (act_o & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl import irq_lvl_pkg::*; #(
  parameter int N_SRC     = 8,
  parameter int VADDR_W   = 16,
  parameter int BOOT_BASE = 'h1000,
  parameter int VEC_BYTES = 4,
  localparam int VEC_W    = $clog2(N_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SRC-1:0]   req_i,
  input  logic [N_SRC-1:0]   en_i,
  input  logic [2*N_SRC-1:0] lvl_cfg_i,
  input  logic               glb_en_i,
  input  logic               rr_mode_i,
  input  logic               vbase_sel_i,
  input  logic               ack_i,
  input  logic               reti_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [1:0]         lvl_o,
  output logic [VADDR_W-1:0] vaddr_o,
  output logic [2:0]         active_o
);
  logic [N_SRC-1:0] low_req, med_req, high_req;
  logic             hi_any, md_any, lf_any, lr_any;
  logic [VEC_W-1:0] hi_idx, md_idx, lf_idx, lr_idx;
  logic [VEC_W-1:0] rr_last;
  logic [1:0]       act_top;
  logic             take;

  logic             cand_v;
  logic [VEC_W-1:0] cand_vec;
  logic [1:0]       cand_lvl;
  logic [VADDR_W-1:0] cand_addr;

  irq_level_mask #(.N_SRC(N_SRC)) u_mask (
    .req_i(req_i), .en_i(en_i), .lvl_cfg_i(lvl_cfg_i), .glb_en_i(glb_en_i),
    .low_o(low_req), .med_o(med_req), .high_o(high_req)
  );

  irq_fixed_pick #(.N_SRC(N_SRC)) u_pick_hi (.req_i(high_req), .any_o(hi_any), .idx_o(hi_idx));
  irq_fixed_pick #(.N_SRC(N_SRC)) u_pick_md (.req_i(med_req),  .any_o(md_any), .idx_o(md_idx));
  irq_fixed_pick #(.N_SRC(N_SRC)) u_pick_lf (.req_i(low_req),  .any_o(lf_any), .idx_o(lf_idx));
  irq_rr_pick    #(.N_SRC(N_SRC)) u_pick_lr (.req_i(low_req), .last_i(rr_last),
                                             .any_o(lr_any), .idx_o(lr_idx));

  assign take = ack_i & irq_o;

  irq_status_track u_status (
    .clk(clk), .rst(rst), .set_i(take), .set_lvl_i(lvl_o), .clr_i(reti_i),
    .act_o(active_o), .top_o(act_top)
  );

  // Level selection: strictly above the highest executing level
  always_comb begin
    cand_v   = 1'b0;
    cand_vec = '0;
    cand_lvl = LVL_OFF;
    if (hi_any && LVL_HIGH > act_top) begin
      cand_v = 1'b1; cand_vec = hi_idx; cand_lvl = LVL_HIGH;
    end else if (md_any && LVL_MED > act_top) begin
      cand_v = 1'b1; cand_vec = md_idx; cand_lvl = LVL_MED;
    end else if (lf_any && LVL_LOW > act_top) begin
      cand_v = 1'b1; cand_vec = rr_mode_i ? lr_idx : lf_idx; cand_lvl = LVL_LOW;
    end
    cand_addr = (vbase_sel_i ? VADDR_W'(BOOT_BASE) : '0)
              + VADDR_W'(cand_vec) * VADDR_W'(VEC_BYTES);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o   <= 1'b0;
      vec_o   <= '0;
      lvl_o   <= LVL_OFF;
      vaddr_o <= '0;
      rr_last <= '0;
    end else begin
      irq_o   <= cand_v & ~(ack_i | reti_i);
      vec_o   <= cand_vec;
      lvl_o   <= cand_lvl;
      vaddr_o <= cand_addr;
      if (take && lvl_o == LVL_LOW) rr_last <= vec_o;
    end
  end
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk import irq_lvl_pkg::*; #(
  parameter int N_SRC     = 8,
  parameter int VADDR_W   = 16,
  parameter int BOOT_BASE = 'h1000,
  parameter int VEC_BYTES = 4,
  localparam int VEC_W    = $clog2(N_SRC)
) (
  input logic               clk,
  input logic               rst,
  input logic               glb_en_i,
  input logic               vbase_sel_i,
  input logic               ack_i,
  input logic               reti_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [1:0]         lvl_o,
  input logic [VADDR_W-1:0] vaddr_o,
  input logic [2:0]         active_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!irq_o && active_o == 3'b0)); // R1
  AST_LEVEL_CODED: assert property (@(posedge clk) disable iff (rst) irq_o |-> lvl_o != LVL_OFF); // R2
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst) !glb_en_i |=> !irq_o); // R4
  AST_STRICT_ABOVE: assert property (@(posedge clk) disable iff (rst) irq_o |-> lvl_o > top_level(active_o)); // R5
  AST_ACK_SETS: assert property (@(posedge clk) disable iff (rst)
    (ack_i && irq_o && !reti_i) |=> active_o[$past(lvl_o) - 2'd1]); // R6
  AST_HANDSHAKE_GAP: assert property (@(posedge clk) disable iff (rst) (ack_i || reti_i) |=> !irq_o); // R6
  AST_RETI_ONE: assert property (@(posedge clk) disable iff (rst)
    (reti_i && !ack_i && active_o != 3'b0) |=> $countones(active_o) == $countones($past(active_o)) - 1); // R7
  AST_VADDR: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> vaddr_o == ($past(vbase_sel_i) ? VADDR_W'(BOOT_BASE) : VADDR_W'(0))
                         + VADDR_W'(vec_o) * VADDR_W'(VEC_BYTES)); // R9
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(
  .N_SRC(N_SRC), .VADDR_W(VADDR_W), .BOOT_BASE(BOOT_BASE), .VEC_BYTES(VEC_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .glb_en_i(glb_en_i), .vbase_sel_i(vbase_sel_i),
  .ack_i(ack_i), .reti_i(reti_i), .irq_o(irq_o), .vec_o(vec_o), .lvl_o(lvl_o),
  .vaddr_o(vaddr_o), .active_o(active_o)
);

// File: tb/irq_level_ctrl_test.sv
`timescale 1ns/1ps
module irq_level_ctrl_test;
  localparam int N = 8;
  localparam int BOOT = 'h1000;
  localparam int VB = 4;

  logic clk = 0, rst = 1;
  logic [N-1:0] req = 0, en = 0;
  logic [2*N-1:0] lvl_cfg = 0;
  logic glb = 0, rr = 0, vsel = 0, ack = 0, reti = 0;
  logic irq; logic [2:0] vec; logic [1:0] lvl; logic [15:0] vaddr; logic [2:0] act;

  int total = 0, bad = 0;
  int cyc = 0;

  // reference model state
  bit e_irq; int e_vec, e_lvl, e_addr; int e_act, rr_last;
  bit m_v; int m_vec, m_lvl;

  irq_level_ctrl #(.N_SRC(N), .VADDR_W(16), .BOOT_BASE(BOOT), .VEC_BYTES(VB)) uut (
    .clk(clk), .rst(rst), .req_i(req), .en_i(en), .lvl_cfg_i(lvl_cfg), .glb_en_i(glb),
    .rr_mode_i(rr), .vbase_sel_i(vsel), .ack_i(ack), .reti_i(reti),
    .irq_o(irq), .vec_o(vec), .lvl_o(lvl), .vaddr_o(vaddr), .active_o(act));

  always #5 clk = ~clk;

  function automatic int top_of(int a);
    if (a[2]) return 3; if (a[1]) return 2; if (a[0]) return 1; return 0;
  endfunction

  function automatic bit elig(int i, int lv);
    return req[i] && en[i] && glb && (int'(lvl_cfg[2*i +: 2]) == lv);
  endfunction

  task automatic model_pick();
    m_v = 0; m_vec = 0; m_lvl = 0;
    for (int lv = 3; lv >= 1 && !m_v; lv--) begin
      if (lv <= top_of(e_act)) continue;
      for (int k = 0; k < N && !m_v; k++) begin
        int i;
        i = (lv == 1 && rr) ? (rr_last + 1 + k) % N : k;
        if (elig(i, lv)) begin m_v = 1; m_vec = i; m_lvl = lv; end
      end
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      e_irq = 0; e_act = 0; rr_last = 0; e_vec = 0; e_lvl = 0; e_addr = 0;
    end else begin
      int na;
      model_pick();
      na = e_act;
      if (reti && top_of(e_act) > 0) na[top_of(e_act)-1] = 0;
      if (ack && e_irq) begin
        na[e_lvl-1] = 1;
        if (e_lvl == 1) rr_last = e_vec;
      end
      e_act = na;
      e_irq = m_v && !(ack || reti);
      e_vec = m_vec; e_lvl = m_lvl;
      e_addr = (vsel ? BOOT : 0) + m_vec * VB;
    end
  end

  task automatic chk(string tag, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, actual, expected, cyc);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    chk("R2 model irq", int'(irq), int'(e_irq));
    chk("R6 model active", int'(act), e_act);
    if (e_irq) begin
      chk("R3 model vec", int'(vec), e_vec);
      chk("R2 model lvl", int'(lvl), e_lvl);
      chk("R9 model vaddr", int'(vaddr), e_addr);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack();
    ack = 1; step(); ack = 0;
  endtask

  task automatic do_reti();
    reti = 1; step(); reti = 0;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // lines 0..5 low, line 6 medium, line 7 high
    for (int i = 0; i < N; i++) lvl_cfg[2*i +: 2] = (i == 7) ? 2'b11 : (i == 6) ? 2'b10 : 2'b01;
    step(3);
    chk("R1 reset irq", int'(irq), 0);
    chk("R1 reset active", int'(act), 0);
    rst = 0; en = '1; glb = 1;
    step();

    // R3 fixed order within low
    req = 8'b0010_0100;
    #1 chk("R10 no change before edge", int'(irq), 0);
    step();
    chk("R3 low smallest index", int'(vec), 2);
    chk("R2 low level code", int'(lvl), 1);
    req[6] = 1; step();
    chk("R2 medium beats low", int'(vec), 6);
    req[7] = 1; step();
    chk("R2 high beats medium", int'(vec), 7);
    chk("R9 base zero", int'(vaddr), 7*VB);
    vsel = 1; step();
    chk("R9 boot base", int'(vaddr), BOOT + 7*VB);
    vsel = 0;

    // R4 gating
    glb = 0; step();
    chk("R4 global off", int'(irq), 0);
    glb = 1; en[7] = 0; step();
    chk("R4 line enable off", int'(vec), 6);
    lvl_cfg[13:12] = 2'b00; step();
    chk("R2 off code ignored", int'(vec), 2);
    lvl_cfg[13:12] = 2'b10; step();

    // R5/R6 nesting
    do_ack();
    chk("R6 medium flag set", int'(act), 3'b010);
    chk("R6 irq gap", int'(irq), 0);
    step();
    chk("R5 equal and lower wait", int'(irq), 0);
    en[7] = 1; step();
    chk("R5 higher accepted", int'(vec), 7);
    do_ack();
    chk("R6 high flag set", int'(act), 3'b110);
    step();
    chk("R5 nothing above high", int'(irq), 0);
    req[7] = 0; do_reti();
    chk("R7 high cleared first", int'(act), 3'b010);
    req[6] = 0; do_reti();
    chk("R7 medium cleared", int'(act), 3'b000);
    step();
    chk("R3 low resumes", int'(vec), 2);

    // R8 round robin on lines 1,2,5
    req = 8'b0010_0110; rr = 1;
    step();
    begin
      int seq [4] = '{1, 2, 5, 1};
      for (int r = 0; r < 4; r++) begin
        chk("R8 rotation order", int'(vec), seq[r]);
        do_ack(); do_reti(); step();
      end
    end
    rr = 0; step();
    for (int r = 0; r < 2; r++) begin
      chk("R8 fixed mode stays", int'(vec), 1);
      do_ack(); do_reti(); step();
    end

    // R1 reset mid-run restores pointer
    rr = 1; do_ack();
    rst = 1; step(2);
    chk("R1 reset clears active", int'(act), 0);
    rst = 0; step(2);
    chk("R1 pointer back to zero", int'(vec), 1);

    step(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule